// File: doc/BRIEF.md
# Local Interrupt Acceptance Unit

This block sits beside one processor core and decides which fixed-mode interrupt the core should take next. Each request comes in as an 8-bit vector number with a one-cycle valid strobe. It is latched into a 256-bit pending set. The unit picks the highest-numbered pending vector and presents it only when three conditions hold:

- delivery is enabled by software;
- the vector's priority class (vector bits [7:4]) is above the task priority class;
- the vector's priority class is above the class of the highest vector already in service.

When the core acknowledges, the presented vector moves from the pending set to the in-service set. The vector number is returned on the acknowledge result port. A later end-of-interrupt write retires the top in-service vector.

Software reaches the unit through a simple register port of 32-bit reads and writes at 16-byte-aligned offsets. Through this port it can:

- program the task priority and the spurious vector, and turn delivery on or off;
- read back the pending, in-service and trigger-mode banks;
- read the core identifier and an error status word;
- issue end-of-interrupt.

Acknowledges that find nothing to deliver return the programmed spurious vector.

Top module: `lapic_accept`

## Requirements
- R1: After reset the task priority reads 0, the spurious/enable register reads 0x0FF (delivery off, spurious vector 0xFF), the error status reads 0, every pending and in-service word reads 0 and `intPending` is low.
- R2: Offset 0x020 reads `coreId` in bits [31:24] with all other bits 0; writes to it change nothing.
- R3: A request with a vector of 16 or more sets pending bit v, readable at offset 0x200 + 16*(v/32), bit v%32.
- R4: A request with a vector below 16 is dropped, leaving pending word 0 unchanged, and sets error bit 6 of the error status at 0x280. A write of any value to 0x280 clears the error status. Reads of 0x280 return only bits 7 and 6.
- R5: The register at 0x0F0 holds the spurious vector in bits [7:0] and the delivery enable in bit 8. While bit 8 is 0, `intPending` stays low whatever is pending.
- R6: The presented vector is the highest-numbered pending vector. It is presented only if its class (bits [7:4]) is strictly greater than the class held in bits [7:4] of the task priority register at 0x080, and strictly greater than the class of the highest in-service vector.
- R7: An acknowledge while a vector is presented clears that pending bit and sets its in-service bit. In the next cycle `ackValid` is high and `ackVector` carries the vector. In-service bit v reads at 0x100 + 16*(v/32).
- R8: An acknowledge while nothing is presented returns the spurious vector on `ackVector`, with no change to the pending or in-service sets.
- R9: A write of 0 to offset 0x0B0 clears the highest-numbered set in-service bit.
- R10: A non-zero write to 0x0B0 sets error bit 7 and leaves the in-service set unchanged.
- R11: The task priority and spurious/enable registers read back what was written (bits [7:0] and bits [8:0] respectively).
- R12: The trigger-mode bank at 0x180..0x1F0 always reads 0, since every accepted interrupt is edge-type.
- R13: Read data and `busRvalid` appear in the cycle after `busRead`. Unmapped or non-16-byte-aligned offsets read 0, and writes to them do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coreId | input | 8 | Identifier of the attached core |
| busAddr | input | 12 | Register byte offset |
| busWrite | input | 1 | Write strobe |
| busRead | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| busRvalid | output | 1 | Read data valid, one cycle after `busRead` |
| irqValid | input | 1 | Interrupt request strobe |
| irqVector | input | 8 | Requested vector |
| intPending | output | 1 | A vector is ready for the core |
| intVector | output | 8 | Vector currently presented |
| intAck | input | 1 | Core acknowledge |
| ackValid | output | 1 | Acknowledge result valid, one cycle after `intAck` |
| ackVector | output | 8 | Delivered or spurious vector |

## Verification
Register writes, requests, acknowledges and end-of-interrupt writes all take effect at the edge that samples them. The presented vector on `intPending`/`intVector` is therefore checked at the falling edge that follows that sampling edge. Read data and acknowledge results are registered once, so they are due one cycle after the strobe. A monitor compares each `busRvalid` or `ackValid` beat, at the falling edge, against the head of a queue filled by the driver tasks. Results that come early, late or not at all leave a queue out of step, and that shows up as a mismatch or as a non-empty queue at the end.

// File: rtl/lapic_accept_pkg.sv
package lapic_accept_pkg;
  localparam int NUM_VEC   = 256;
  localparam int VEC_W     = $clog2(NUM_VEC);
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = NUM_VEC / WORD_W;
  localparam int WIDX_W    = $clog2(NUM_WORDS);
  localparam int ADDR_W    = 12;
  localparam int BANK_W    = ADDR_W - 4;

  // 16-byte register slots, addressed by busAddr[11:4]
  localparam logic [BANK_W-1:0] SLOT_ID  = 8'h02;
  localparam logic [BANK_W-1:0] SLOT_TPR = 8'h08;
  localparam logic [BANK_W-1:0] SLOT_EOI = 8'h0B;
  localparam logic [BANK_W-1:0] SLOT_SVR = 8'h0F;
  localparam logic [BANK_W-1:0] SLOT_ESR = 8'h28;
  // banks of NUM_WORDS slots, matched on the upper slot bits
  localparam logic [BANK_W-WIDX_W-1:0] GRP_ISR = 5'b00010;
  localparam logic [BANK_W-WIDX_W-1:0] GRP_TMR = 5'b00011;
  localparam logic [BANK_W-WIDX_W-1:0] GRP_IRR = 5'b00100;

  typedef enum logic [2:0] {
    RD_NONE, RD_ID, RD_TPR, RD_SVR, RD_ISR, RD_TMR, RD_IRR, RD_ESR
  } rdKind_t;

  typedef struct packed {
    logic              wrTpr;
    logic              wrSvr;
    logic              clrEsr;
    logic              eoiOk;
    logic              eoiBad;
    logic              rdEn;
    rdKind_t           rdKind;
    logic [WIDX_W-1:0] rdWord;
  } ctlStrobes_t;
endpackage

// File: rtl/lapic_prio_find.sv
module lapic_prio_find #(
  parameter int N = 256,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] bits,
  output logic         found,
  output logic [W-1:0] idx
);
  // highest set index wins: later loop iterations override earlier ones
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (bits[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/lapic_reg_ctrl.sv
module lapic_reg_ctrl
  import lapic_accept_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [WORD_W-1:0] busWdata,
  output ctlStrobes_t       ctl
);
  logic [BANK_W-1:0]        slot;
  logic [BANK_W-WIDX_W-1:0] grp;
  logic                     aligned;

  assign slot    = busAddr[ADDR_W-1:4];
  assign grp     = slot[BANK_W-1:WIDX_W];
  assign aligned = (busAddr[3:0] == 4'h0);

  always_comb begin
    ctl        = '0;
    ctl.rdKind = RD_NONE;
    if (busWrite && aligned) begin
      unique case (slot)
        SLOT_TPR: ctl.wrTpr  = 1'b1;
        SLOT_SVR: ctl.wrSvr  = 1'b1;
        SLOT_ESR: ctl.clrEsr = 1'b1;
        SLOT_EOI: begin
          ctl.eoiOk  = (busWdata == '0);
          ctl.eoiBad = (busWdata != '0);
        end
        default: ;
      endcase
    end
    if (busRead) begin
      ctl.rdEn   = 1'b1;
      ctl.rdWord = slot[WIDX_W-1:0];
      if (aligned) begin
        if      (slot == SLOT_ID)  ctl.rdKind = RD_ID;
        else if (slot == SLOT_TPR) ctl.rdKind = RD_TPR;
        else if (slot == SLOT_SVR) ctl.rdKind = RD_SVR;
        else if (slot == SLOT_ESR) ctl.rdKind = RD_ESR;
        else if (grp == GRP_ISR)   ctl.rdKind = RD_ISR;
        else if (grp == GRP_TMR)   ctl.rdKind = RD_TMR;
        else if (grp == GRP_IRR)   ctl.rdKind = RD_IRR;
      end
    end
  end
endmodule

// File: rtl/lapic_accept_dp.sv
module lapic_accept_dp
  import lapic_accept_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobes_t       ctl,
  input  logic [8:0]        wrLow,
  input  logic [7:0]        coreId,
  input  logic              irqValid,
  input  logic [VEC_W-1:0]  irqVector,
  input  logic              intAck,
  output logic [WORD_W-1:0] busRdata,
  output logic              busRvalid,
  output logic              intPending,
  output logic [VEC_W-1:0]  intVector,
  output logic              ackValid,
  output logic [VEC_W-1:0]  ackVector
);
  localparam logic [NUM_VEC-1:0] ONE_HOT0 = NUM_VEC'(1);

  logic [NUM_VEC-1:0] irr, isr, reqSet, ackBit, eoiBit;
  logic [VEC_W-1:0]   tpr, svrVec, pendVec, svcVec;
  logic               svrEn, esrIllegal, esrEoi;
  logic               pendFound, svcFound, presentable, ackTake, reqIllegal;
  logic [WORD_W-1:0]  irrWords [NUM_WORDS];
  logic [WORD_W-1:0]  isrWords [NUM_WORDS];
  logic [WORD_W-1:0]  rdMux;

  lapic_prio_find #(.N(NUM_VEC), .W(VEC_W)) u_pendTop (
    .bits(irr), .found(pendFound), .idx(pendVec));
  lapic_prio_find #(.N(NUM_VEC), .W(VEC_W)) u_svcTop (
    .bits(isr), .found(svcFound), .idx(svcVec));

  assign presentable = svrEn && pendFound && (pendVec[7:4] > tpr[7:4]) &&
                       (!svcFound || (pendVec[7:4] > svcVec[7:4]));
  assign intPending  = presentable;
  assign intVector   = pendVec;
  assign ackTake     = intAck && presentable;
  assign reqIllegal  = irqValid && (irqVector[7:4] == 4'h0);

  assign reqSet = (irqValid && !reqIllegal) ? (ONE_HOT0 << irqVector) : '0;
  assign ackBit = ackTake ? (ONE_HOT0 << pendVec) : '0;
  assign eoiBit = (ctl.eoiOk && svcFound) ? (ONE_HOT0 << svcVec) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr        <= '0;
      isr        <= '0;
      tpr        <= '0;
      svrVec     <= 8'hFF;
      svrEn      <= 1'b0;
      esrIllegal <= 1'b0;
      esrEoi     <= 1'b0;
      ackValid   <= 1'b0;
      ackVector  <= '0;
    end else begin
      irr        <= (irr & ~ackBit) | reqSet;
      isr        <= (isr & ~eoiBit) | ackBit;
      if (ctl.wrTpr) tpr <= wrLow[7:0];
      if (ctl.wrSvr) begin
        svrVec <= wrLow[7:0];
        svrEn  <= wrLow[8];
      end
      esrIllegal <= (esrIllegal && !ctl.clrEsr) || reqIllegal;
      esrEoi     <= (esrEoi && !ctl.clrEsr) || ctl.eoiBad;
      ackValid   <= intAck;
      ackVector  <= ackTake ? pendVec : svrVec;
    end
  end

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_words
    assign irrWords[w] = irr[w*WORD_W +: WORD_W];
    assign isrWords[w] = isr[w*WORD_W +: WORD_W];
  end

  always_comb begin
    unique case (ctl.rdKind)
      RD_ID:   rdMux = {coreId, 24'h0};
      RD_TPR:  rdMux = {24'h0, tpr};
      RD_SVR:  rdMux = {23'h0, svrEn, svrVec};
      RD_ISR:  rdMux = isrWords[ctl.rdWord];
      RD_IRR:  rdMux = irrWords[ctl.rdWord];
      RD_ESR:  rdMux = {24'h0, esrEoi, esrIllegal, 6'h0};
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busRvalid <= 1'b0;
      busRdata  <= '0;
    end else begin
      busRvalid <= ctl.rdEn;
      busRdata  <= ctl.rdEn ? rdMux : '0;
    end
  end

  // R7
  ack_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intAck && intPending |=> ackValid && ackVector == $past(intVector) &&
                             isr[$past(intVector)]);
  // R8
  spurious_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    intAck && !intPending && !ctl.eoiOk |=> ackVector == $past(svrVec) && $stable(isr));
  // R4
  illegal_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqIllegal |=> esrIllegal && irr[15:0] == 16'h0);
  // R10
  eoi_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.eoiBad && !intAck |=> esrEoi && $stable(isr));
  // R9
  eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.eoiOk && svcFound && !intAck |=> !isr[$past(svcVec)]);
endmodule

// File: rtl/lapic_accept.sv
module lapic_accept
  import lapic_accept_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        coreId,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrite,
  input  logic              busRead,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  output logic              busRvalid,
  input  logic              irqValid,
  input  logic [VEC_W-1:0]  irqVector,
  output logic              intPending,
  output logic [VEC_W-1:0]  intVector,
  input  logic              intAck,
  output logic              ackValid,
  output logic [VEC_W-1:0]  ackVector
);
  ctlStrobes_t ctl;

  lapic_reg_ctrl u_ctrl (
    .busAddr(busAddr), .busWrite(busWrite), .busRead(busRead),
    .busWdata(busWdata), .ctl(ctl));

  lapic_accept_dp u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .wrLow(busWdata[8:0]),
    .coreId(coreId), .irqValid(irqValid), .irqVector(irqVector),
    .intAck(intAck), .busRdata(busRdata), .busRvalid(busRvalid),
    .intPending(intPending), .intVector(intVector),
    .ackValid(ackValid), .ackVector(ackVector));
endmodule

// File: tb/lapic_accept_bench.sv
module lapic_accept_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  coreId = 8'h5A;
  logic [11:0] busAddr = '0;
  logic        busWrite = 1'b0, busRead = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic        irqValid = 1'b0;
  logic [7:0]  irqVector = '0;
  logic        intPending;
  logic [7:0]  intVector;
  logic        intAck = 1'b0;
  logic        ackValid;
  logic [7:0]  ackVector;

  int checks = 0, errors = 0;
  logic [31:0] rdExpQ[$];
  string       rdReqQ[$];
  logic [7:0]  ackExpQ[$];
  string       ackReqQ[$];

  always #4 clk = ~clk;  // 125 MHz

  lapic_accept u_lapic_accept (
    .clk(clk), .rst_n(rst_n), .coreId(coreId), .busAddr(busAddr),
    .busWrite(busWrite), .busRead(busRead), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid), .irqValid(irqValid),
    .irqVector(irqVector), .intPending(intPending), .intVector(intVector),
    .intAck(intAck), .ackValid(ackValid), .ackVector(ackVector));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: results arrive one cycle after their strobe
  always @(negedge clk) begin
    if (busRvalid) begin
      if (rdExpQ.size() == 0) check("R13 unexpected read data", 32'h1, 32'h0);
      else check(rdReqQ.pop_front(), busRdata, rdExpQ.pop_front());
    end
    if (ackValid) begin
      if (ackExpQ.size() == 0) check("R7 unexpected ack", 32'h1, 32'h0);
      else check(ackReqQ.pop_front(), {24'h0, ackVector}, {24'h0, ackExpQ.pop_front()});
    end
  end

  task automatic busWr(logic [11:0] a, logic [31:0] d);
    @(posedge clk); #1 busAddr = a; busWdata = d; busWrite = 1'b1;
    @(posedge clk); #1 busWrite = 1'b0;
  endtask

  task automatic busRd(logic [11:0] a, logic [31:0] exp, string req);
    rdExpQ.push_back(exp); rdReqQ.push_back(req);
    @(posedge clk); #1 busAddr = a; busRead = 1'b1;
    @(posedge clk); #1 busRead = 1'b0;
  endtask

  task automatic raise(logic [7:0] v);
    @(posedge clk); #1 irqVector = v; irqValid = 1'b1;
    @(posedge clk); #1 irqValid = 1'b0;
  endtask

  task automatic ack(logic [7:0] exp, string req);
    ackExpQ.push_back(exp); ackReqQ.push_back(req);
    @(posedge clk); #1 intAck = 1'b1;
    @(posedge clk); #1 intAck = 1'b0;
  endtask

  task automatic chkInt(logic pend, logic [7:0] vec, string req);
    @(negedge clk);
    check(req, {31'h0, intPending}, {31'h0, pend});
    if (pend) check(req, {24'h0, intVector}, {24'h0, vec});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog expired", 32'h1, 32'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    chkInt(1'b0, 8'h0, "R1 no interrupt after reset");
    busRd(12'h080, 32'h0, "R1 tpr reset");
    busRd(12'h0F0, 32'h0FF, "R1 svr reset");
    busRd(12'h280, 32'h0, "R1 esr reset");
    busRd(12'h200, 32'h0, "R1 irr reset");
    busRd(12'h100, 32'h0, "R1 isr reset");
    // R2 identifier
    busRd(12'h020, 32'h5A00_0000, "R2 id read");
    busWr(12'h020, 32'h0);
    busRd(12'h020, 32'h5A00_0000, "R2 id write ignored");
    // R3 / R5 latch while delivery is off
    raise(8'h45);
    busRd(12'h220, 32'h0000_0020, "R3 irr word2 bit5");
    chkInt(1'b0, 8'h0, "R5 disabled gates delivery");
    ack(8'hFF, "R8 spurious while disabled");
    busRd(12'h220, 32'h0000_0020, "R8 irr kept");
    // R11 / R5 enable with spurious 0x3F
    busWr(12'h0F0, 32'h13F);
    busRd(12'h0F0, 32'h13F, "R11 svr readback");
    chkInt(1'b1, 8'h45, "R5 enabled delivery");
    raise(8'h80);
    raise(8'h31);
    chkInt(1'b1, 8'h80, "R6 highest pending");
    busRd(12'h210, 32'h0002_0000, "R3 irr word1 bit17");
    // R6 task priority gating
    busWr(12'h080, 32'h80);
    chkInt(1'b0, 8'h0, "R6 tpr class equal blocks");
    ack(8'h3F, "R8 spurious vector programmed");
    busWr(12'h080, 32'h70);
    busRd(12'h080, 32'h70, "R11 tpr readback");
    chkInt(1'b1, 8'h80, "R6 tpr lower passes");
    // R7 acknowledge
    ack(8'h80, "R7 ack delivers 0x80");
    busRd(12'h140, 32'h0000_0001, "R7 isr set");
    busRd(12'h240, 32'h0, "R7 irr cleared");
    chkInt(1'b0, 8'h0, "R6 lower class than tpr");
    raise(8'h85);
    chkInt(1'b0, 8'h0, "R6 equal to in-service class blocks");
    raise(8'h95);
    chkInt(1'b1, 8'h95, "R6 higher class nests");
    ack(8'h95, "R7 ack delivers 0x95");
    busRd(12'h140, 32'h0020_0001, "R7 two in service");
    chkInt(1'b0, 8'h0, "R6 blocked by in-service");
    // R10 bad EOI
    busWr(12'h0B0, 32'h5);
    busRd(12'h280, 32'h80, "R10 esr bit7");
    busRd(12'h140, 32'h0020_0001, "R10 isr unchanged");
    // R9 EOI retires top first
    busWr(12'h0B0, 32'h0);
    busRd(12'h140, 32'h0000_0001, "R9 top retired");
    chkInt(1'b0, 8'h0, "R9 0x85 still blocked");
    busWr(12'h0B0, 32'h0);
    busRd(12'h140, 32'h0, "R9 last retired");
    chkInt(1'b1, 8'h85, "R9 pending released");
    // R4 illegal vector
    raise(8'h0A);
    busRd(12'h200, 32'h0, "R4 illegal dropped");
    busRd(12'h280, 32'hC0, "R4 esr bit6");
    busWr(12'h280, 32'h0);
    busRd(12'h280, 32'h0, "R4 esr cleared");
    // R12 / R13
    busRd(12'h180, 32'h0, "R12 trigger bank zero");
    busRd(12'h300, 32'h0, "R13 unmapped zero");
    busRd(12'h084, 32'h0, "R13 misaligned zero");
    // R5 disable again
    busWr(12'h0F0, 32'h0FF);
    chkInt(1'b0, 8'h0, "R5 disabled again");
    ack(8'hFF, "R8 spurious after disable");
    busRd(12'h240, 32'h0000_0020, "R8 irr untouched");
    repeat (3) @(posedge clk);
    check("R13 read queue drained", rdExpQ.size(), 0);
    check("R7 ack queue drained", ackExpQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule